// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Standby Wakeup

This block recovers characters from an asynchronous serial line. The line is sampled once per pulse of `sampleTick`, which runs at sixteen times the bit rate. The baud divider that makes this tick sits outside the block. A character is a start bit, then 8, 9 or 10 bits sent least significant bit first, then one stop bit. When parity is on, the last of those bits is the parity bit. The receiver takes a majority vote of three samples around the centre of each bit and flags any disagreement as noise. It also reports framing and parity errors, an idle line, a long break and every falling edge on the line.

The received word is held in a one-entry output register until `readAck` frees it. A word that arrives while the register is still occupied is dropped and flagged. Two wakeup schemes let software park the receiver in standby, so that traffic meant for other nodes is ignored. In idle-line wakeup, a quiet line of one character time ends standby. In address-mark wakeup, a character whose top data bit is set is an address. It ends standby when it matches a programmed value, or whenever it arrives if matching is off.

Top module: `uart_wake_rx`

## Requirements
- R1: A falling edge starts a character only if the majority of the samples around the centre of the start bit reads low. Otherwise no character is delivered and the receiver waits for the line to return high.
- R2: The number of bits after the start bit is set by `wordMode`: 0 gives 8, 1 gives 9, and 2 or 3 give 10. The bits arrive least significant first. `rxWord` holds only the data bits, right-aligned with zeros above them, and `dataValid` pulses for one clock when a new word is stored.
- R3: When `parityEn` is 1, the last bit is parity and the data is one bit shorter. With `parityOdd`=0, data plus parity must hold an even number of ones; with 1, an odd number. A mismatch raises `parityErr` together with `dataValid`.
- R4: A stop bit whose majority reads low raises `framingErr` together with `dataValid`.
- R5: Each bit is sampled on ticks 7, 8 and 9 of its 16 ticks, and the majority gives its value. A disagreement in any bit of the character, start and stop included, raises `noiseErr` with that character.
- R6: When `brk11En` is 1, a run of at least 11 bit times (176 ticks) of low line gives exactly one `breakDet` pulse. When it is 0, no pulse is given.
- R7: After a character, or after entering standby, a line that stays high for (data-plus-parity bits + 2) bit times gives exactly one `idleDet` pulse. Any low sample restarts the count.
- R8: Each falling edge of the polarity-corrected line gives one `edgeDet` pulse, including edges that do not make a character.
- R9: With `invertRx`=1, the pin is inverted before any other processing, so an idle low pin is treated as a high line.
- R10: A character that completes while the previous word is still unread is discarded. `overrunErr` pulses instead of `dataValid` and `rxWord` keeps its value. `readAck` frees the register.
- R11: With `wakeMode`=1, a `standbyReq` pulse sets `standby`. While in standby no character is delivered, and the next `idleDet` clears `standby`.
- R12: With `wakeMode`=2, the top data bit marks an address. In standby, an address whose lower data bits equal the same bits of `matchAddr` (any address when `matchEn`=0) clears `standby` and is delivered; everything else is ignored. When awake with `matchEn`=1, a non-matching address sets `standby` and is not delivered. With `wakeMode`=0, `standby` stays low.
- R13: `framingErr`, `parityErr` and `noiseErr` are asserted only in a cycle where `dataValid` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | One-clock pulse at 16x the bit rate |
| rxPin | input | 1 | Serial input pin |
| invertRx | input | 1 | Invert pin polarity |
| wordMode | input | 2 | Bits after start: 0=8, 1=9, 2/3=10 |
| parityEn | input | 1 | Last bit is parity |
| parityOdd | input | 1 | 0 even parity, 1 odd parity |
| brk11En | input | 1 | Enable 11-bit break detection |
| wakeMode | input | 2 | 0 none, 1 idle-line, 2 address-mark |
| matchEn | input | 1 | Compare addresses with matchAddr |
| matchAddr | input | 9 | Address compared below the mark bit |
| standbyReq | input | 1 | Pulse: enter standby |
| readAck | input | 1 | Pulse: output word consumed |
| rxWord | output | 10 | Last delivered data bits |
| dataValid | output | 1 | New word stored |
| framingErr | output | 1 | Stop bit read low |
| parityErr | output | 1 | Parity mismatch |
| noiseErr | output | 1 | Sample disagreement in the character |
| overrunErr | output | 1 | Character dropped, register occupied |
| breakDet | output | 1 | Break pulse |
| idleDet | output | 1 | Idle line pulse |
| edgeDet | output | 1 | Falling edge on line |
| standby | output | 1 | Receiver is in standby |

## Verification
The assertions check the cycle-level rules on every clock. The error flags never appear without `dataValid`, and a dropped word never changes `rxWord` or coincides with a delivery. No word is delivered while the receiver is in standby. Breaks appear only when enabled, and the idle indication is a single pulse. Whether the bits are put together correctly is shown only by the bench's scenarios: bit order, the majority vote under an injected glitch, parity polarity, discarded false starts, the two wakeup exits and the address filtering all need whole serial frames driven onto the pin.

// File: rtl/uwr_pkg.sv
package uwr_pkg;
  localparam int UWR_MAX_BITS = 10;
  localparam int UWR_IDX_W = $clog2(UWR_MAX_BITS);

  typedef enum logic [1:0] {WAKE_NONE = 2'd0, WAKE_IDLE = 2'd1, WAKE_ADDR = 2'd2} uwrWake_t;

  typedef enum logic [2:0] {ST_HUNT, ST_READY, ST_START, ST_DATA, ST_STOP} uwrState_t;

  typedef struct packed {
    logic                 startRx;
    logic                 sampleRun;
    logic                 shiftEn;
    logic [UWR_IDX_W-1:0] bitIdx;
    logic                 armIdle;
  } uwrStrobe_t;
endpackage

// File: rtl/uwr_datapath.sv
module uwr_datapath
  import uwr_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int BRK_BITS    = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleTick,
  input  logic                    rxPin,
  input  logic                    invertRx,
  input  logic                    brk11En,
  input  logic [3:0]              wordBits,
  input  uwrStrobe_t              strobe,
  output logic                    lineNow,
  output logic                    decideNow,
  output logic                    majorBit,
  output logic                    noiseNow,
  output logic                    noiseAcc,
  output logic [UWR_MAX_BITS-1:0] shiftData,
  output logic                    breakPulse,
  output logic                    idlePulse,
  output logic                    edgePulse
);
  localparam int SUB_W     = $clog2(OSR);
  localparam int MID       = OSR / 2;
  localparam int BRK_TICKS = BRK_BITS * OSR;
  localparam int LOW_W     = $clog2(BRK_TICKS + 1);
  localparam int IDLE_MAX  = (UWR_MAX_BITS + 2) * OSR;
  localparam int IDLE_W    = $clog2(IDLE_MAX + 1);
  localparam logic [SUB_W-1:0] SUB_A = SUB_W'(MID - 1);
  localparam logic [SUB_W-1:0] SUB_B = SUB_W'(MID);
  localparam logic [SUB_W-1:0] SUB_C = SUB_W'(MID + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineQ;
  logic [SUB_W-1:0]       subCnt;
  logic                   sampA, sampB;
  logic [LOW_W-1:0]       lowCnt;
  logic [IDLE_W-1:0]      highCnt;
  logic [IDLE_W-1:0]      charTicks;
  logic                   idleArmed;

  // input synchronizer, one flop per stage
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[0] <= 1'b1;
        else       syncQ[0] <= rxPin;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[g] <= 1'b1;
        else       syncQ[g] <= syncQ[g-1];
    end
  end

  assign lineNow = syncQ[SYNC_STAGES-1] ^ invertRx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ     <= 1'b1;
      edgePulse <= 1'b0;
    end else begin
      lineQ     <= lineNow;
      edgePulse <= lineQ & ~lineNow;
    end
  end

  // sub-bit counter and centre samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt <= '0;
      sampA  <= 1'b1;
      sampB  <= 1'b1;
    end else if (sampleTick) begin
      if (strobe.startRx) begin
        subCnt <= SUB_W'(1);
      end else if (strobe.sampleRun) begin
        subCnt <= subCnt + SUB_W'(1);
        if (subCnt == SUB_A) sampA <= lineNow;
        if (subCnt == SUB_B) sampB <= lineNow;
      end
    end
  end

  assign decideNow = sampleTick && strobe.sampleRun && (subCnt == SUB_C);
  assign majorBit  = (sampA & sampB) | (sampA & lineNow) | (sampB & lineNow);
  assign noiseNow  = !((sampA == sampB) && (sampB == lineNow));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      noiseAcc  <= 1'b0;
      shiftData <= '0;
    end else if (sampleTick && strobe.startRx) begin
      noiseAcc  <= 1'b0;
      shiftData <= '0;
    end else if (decideNow) begin
      if (noiseNow) noiseAcc <= 1'b1;
      if (strobe.shiftEn) shiftData[strobe.bitIdx] <= majorBit;
    end
  end

  // break: run of low ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt     <= '0;
      breakPulse <= 1'b0;
    end else begin
      breakPulse <= 1'b0;
      if (sampleTick) begin
        if (lineNow) begin
          lowCnt <= '0;
        end else if (lowCnt != LOW_W'(BRK_TICKS)) begin
          lowCnt <= lowCnt + LOW_W'(1);
          if (lowCnt == LOW_W'(BRK_TICKS - 1)) breakPulse <= brk11En;
        end
      end
    end
  end

  // idle: one character time of high after arming
  always_comb charTicks = IDLE_W'((int'(wordBits) + 2) * OSR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt   <= '0;
      idleArmed <= 1'b0;
      idlePulse <= 1'b0;
    end else begin
      idlePulse <= 1'b0;
      if (strobe.armIdle) begin
        idleArmed <= 1'b1;
        highCnt   <= '0;
      end else if (sampleTick) begin
        if (!lineNow) begin
          highCnt <= '0;
        end else if (idleArmed) begin
          if (highCnt == charTicks - IDLE_W'(1)) begin
            idlePulse <= 1'b1;
            idleArmed <= 1'b0;
            highCnt   <= '0;
          end else begin
            highCnt <= highCnt + IDLE_W'(1);
          end
        end
      end
    end
  end

  assert_break_enabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    breakPulse |-> $past(brk11En));

  assert_idle_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    idlePulse |=> !idlePulse);
endmodule

// File: rtl/uwr_control.sv
module uwr_control
  import uwr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleTick,
  input  logic                    lineNow,
  input  logic                    decideNow,
  input  logic                    majorBit,
  input  logic                    noiseNow,
  input  logic                    noiseAcc,
  input  logic [UWR_MAX_BITS-1:0] shiftData,
  input  logic                    idlePulse,
  input  logic [1:0]              wordMode,
  input  logic                    parityEn,
  input  logic                    parityOdd,
  input  logic [1:0]              wakeMode,
  input  logic                    matchEn,
  input  logic [8:0]              matchAddr,
  input  logic                    standbyReq,
  input  logic                    readAck,
  output uwrStrobe_t              strobe,
  output logic [3:0]              wordBits,
  output logic [UWR_MAX_BITS-1:0] rxWord,
  output logic                    dataValid,
  output logic                    framingErr,
  output logic                    parityErr,
  output logic                    noiseErr,
  output logic                    overrunErr,
  output logic                    standby
);
  uwrState_t             state;
  logic [UWR_IDX_W-1:0]  bitIdx;
  logic                  wordFull;
  logic [3:0]            dataBits;
  logic [UWR_MAX_BITS:0] maskWide;
  logic [UWR_MAX_BITS-1:0] dataMask, dataWord;
  logic                  parityRx, parityExp, markBit, addrHit, isAddr;
  logic                  frameEnd, deliver, enterStandby;
  uwrWake_t              wake;

  assign wake         = uwrWake_t'(wakeMode);
  assign wordBits     = (wordMode[1]) ? 4'd10 : (4'd8 + {3'b0, wordMode[0]});
  assign dataBits     = wordBits - {3'b0, parityEn};
  assign maskWide     = (11'd1 << dataBits) - 11'd1;
  assign dataMask     = maskWide[UWR_MAX_BITS-1:0];
  assign dataWord     = shiftData & dataMask;
  assign parityRx     = shiftData[wordBits - 4'd1];
  assign parityExp    = (^dataWord) ^ parityOdd;
  assign markBit      = shiftData[dataBits - 4'd1];
  assign addrHit      = (((dataWord ^ {1'b0, matchAddr}) & (dataMask >> 1)) == '0);
  assign isAddr       = (wake == WAKE_ADDR) && markBit;
  assign frameEnd     = decideNow && (state == ST_STOP);
  assign enterStandby = standbyReq && (wake != WAKE_NONE);
  assign deliver      = frameEnd && (standby ? (isAddr && (!matchEn || addrHit))
                                             : !(isAddr && matchEn && !addrHit));

  always_comb begin
    strobe.startRx   = (state == ST_READY) && !lineNow;
    strobe.sampleRun = (state == ST_START) || (state == ST_DATA) || (state == ST_STOP);
    strobe.shiftEn   = (state == ST_DATA);
    strobe.bitIdx    = bitIdx;
    strobe.armIdle   = frameEnd || enterStandby;
  end

  // frame sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_HUNT;
      bitIdx <= '0;
    end else if (sampleTick) begin
      unique case (state)
        ST_HUNT:  if (lineNow) state <= ST_READY;
        ST_READY: if (!lineNow) state <= ST_START;
        ST_START: if (decideNow) begin
          state  <= majorBit ? ST_HUNT : ST_DATA;
          bitIdx <= '0;
        end
        ST_DATA: if (decideNow) begin
          if (bitIdx == UWR_IDX_W'(wordBits - 4'd1)) state <= ST_STOP;
          else bitIdx <= bitIdx + UWR_IDX_W'(1);
        end
        ST_STOP: if (decideNow) state <= ST_HUNT;
        default: state <= ST_HUNT;
      endcase
    end
  end

  // standby / wakeup
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      standby <= 1'b0;
    end else if (wake == WAKE_NONE) begin
      standby <= 1'b0;
    end else if (standbyReq) begin
      standby <= 1'b1;
    end else if (frameEnd && standby && isAddr && (!matchEn || addrHit)) begin
      standby <= 1'b0;
    end else if (frameEnd && !standby && isAddr && matchEn && !addrHit) begin
      standby <= 1'b1;
    end else if (standby && (wake == WAKE_IDLE) && idlePulse) begin
      standby <= 1'b0;
    end
  end

  // output word and status strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxWord     <= '0;
      wordFull   <= 1'b0;
      dataValid  <= 1'b0;
      framingErr <= 1'b0;
      parityErr  <= 1'b0;
      noiseErr   <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      dataValid  <= 1'b0;
      framingErr <= 1'b0;
      parityErr  <= 1'b0;
      noiseErr   <= 1'b0;
      overrunErr <= 1'b0;
      if (deliver && wordFull) begin
        overrunErr <= 1'b1;
      end else if (deliver) begin
        rxWord     <= dataWord;
        wordFull   <= 1'b1;
        dataValid  <= 1'b1;
        framingErr <= !majorBit;
        parityErr  <= parityEn && (parityRx != parityExp);
        noiseErr   <= noiseAcc || noiseNow;
      end else if (readAck) begin
        wordFull <= 1'b0;
      end
    end
  end

  assert_valid_awake_R11: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> !standby);

  assert_flags_need_valid_R13: assert property (@(posedge clk) disable iff (!rstN)
    (framingErr || parityErr || noiseErr) |-> dataValid);

  assert_overrun_keeps_word_R10: assert property (@(posedge clk) disable iff (!rstN)
    overrunErr |-> ($stable(rxWord) && !dataValid));

  assert_no_standby_off_R12: assert property (@(posedge clk) disable iff (!rstN)
    (wakeMode == 2'd0) |=> !standby);
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
  import uwr_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int BRK_BITS    = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxPin,
  input  logic       invertRx,
  input  logic [1:0] wordMode,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       brk11En,
  input  logic [1:0] wakeMode,
  input  logic       matchEn,
  input  logic [8:0] matchAddr,
  input  logic       standbyReq,
  input  logic       readAck,
  output logic [9:0] rxWord,
  output logic       dataValid,
  output logic       framingErr,
  output logic       parityErr,
  output logic       noiseErr,
  output logic       overrunErr,
  output logic       breakDet,
  output logic       idleDet,
  output logic       edgeDet,
  output logic       standby
);
  uwrStrobe_t              strobe;
  logic                    lineNow, decideNow, majorBit, noiseNow, noiseAcc;
  logic [UWR_MAX_BITS-1:0] shiftData;
  logic [3:0]              wordBits;

  uwr_datapath #(.OSR(OSR), .BRK_BITS(BRK_BITS), .SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxPin(rxPin),
    .invertRx(invertRx), .brk11En(brk11En), .wordBits(wordBits), .strobe(strobe),
    .lineNow(lineNow), .decideNow(decideNow), .majorBit(majorBit),
    .noiseNow(noiseNow), .noiseAcc(noiseAcc), .shiftData(shiftData),
    .breakPulse(breakDet), .idlePulse(idleDet), .edgePulse(edgeDet)
  );

  uwr_control i_control (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .lineNow(lineNow),
    .decideNow(decideNow), .majorBit(majorBit), .noiseNow(noiseNow),
    .noiseAcc(noiseAcc), .shiftData(shiftData), .idlePulse(idleDet),
    .wordMode(wordMode), .parityEn(parityEn), .parityOdd(parityOdd),
    .wakeMode(wakeMode), .matchEn(matchEn), .matchAddr(matchAddr),
    .standbyReq(standbyReq), .readAck(readAck), .strobe(strobe),
    .wordBits(wordBits), .rxWord(rxWord), .dataValid(dataValid),
    .framingErr(framingErr), .parityErr(parityErr), .noiseErr(noiseErr),
    .overrunErr(overrunErr), .standby(standby)
  );
endmodule

// File: tb/test_uart_wake_rx.sv
module test_uart_wake_rx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxPin = 1'b1;
  logic       invertRx = 1'b0;
  logic [1:0] wordMode = 2'd0;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       brk11En = 1'b0;
  logic [1:0] wakeMode = 2'd0;
  logic       matchEn = 1'b0;
  logic [8:0] matchAddr = 9'd0;
  logic       standbyReq = 1'b0;
  logic       readAck = 1'b0;
  logic [9:0] rxWord;
  logic       dataValid, framingErr, parityErr, noiseErr, overrunErr;
  logic       breakDet, idleDet, edgeDet, standby;

  int checks = 0;
  int errors = 0;
  int validCnt = 0, ovrCnt = 0, idleCnt = 0, brkCnt = 0, edgeCnt = 0;
  logic [9:0] capWord = '0;
  logic capFe = 0, capPe = 0, capNe = 0;

  always #2.5 clk = ~clk;

  uart_wake_rx i_uart_wake_rx (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxPin(rxPin),
    .invertRx(invertRx), .wordMode(wordMode), .parityEn(parityEn),
    .parityOdd(parityOdd), .brk11En(brk11En), .wakeMode(wakeMode),
    .matchEn(matchEn), .matchAddr(matchAddr), .standbyReq(standbyReq),
    .readAck(readAck), .rxWord(rxWord), .dataValid(dataValid),
    .framingErr(framingErr), .parityErr(parityErr), .noiseErr(noiseErr),
    .overrunErr(overrunErr), .breakDet(breakDet), .idleDet(idleDet),
    .edgeDet(edgeDet), .standby(standby)
  );

  always @(negedge clk) begin
    if (dataValid) begin
      validCnt++;
      capWord = rxWord;
      capFe = framingErr;
      capPe = parityErr;
      capNe = noiseErr;
    end
    if (overrunErr) ovrCnt++;
    if (idleDet) idleCnt++;
    if (breakDet) brkCnt++;
    if (edgeDet) edgeCnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bitsAfterStart(input logic [1:0] m);
    return m[1] ? 10 : 8 + int'(m[0]);
  endfunction

  function automatic logic parityOf(input logic [9:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // one sample tick with the logical line value v
  task automatic sendTick(input logic v);
    @(negedge clk);
    rxPin = v ^ invertRx;
    @(negedge clk);
    @(negedge clk);
    sampleTick = 1'b1;
    @(negedge clk);
    sampleTick = 1'b0;
  endtask

  task automatic sendLevel(input logic v, input int n);
    for (int i = 0; i < n; i++) sendTick(v);
  endtask

  task automatic sendBit(input logic v, input bit glitch);
    for (int j = 0; j < 16; j++) sendTick((glitch && j == 8) ? ~v : v);
  endtask

  task automatic pulseAck();
    @(negedge clk); readAck = 1'b1;
    @(negedge clk); readAck = 1'b0;
  endtask

  task automatic pulseStandby();
    @(negedge clk); standbyReq = 1'b1;
    @(negedge clk); standbyReq = 1'b0;
  endtask

  // send one character; glitchAt: 0 start, 1..n bits, n+1 stop, -1 none
  task automatic runFrame(input logic [9:0] dIn, input bit flipPar, input bit badStop,
                          input int glitchAt, input bit expectValid, input string tag);
    int nBits = bitsAfterStart(wordMode);
    int dBits = nBits - int'(parityEn);
    logic [9:0] mask = 10'((11'd1 << dBits) - 11'd1);
    logic [9:0] d = dIn & mask;
    logic [9:0] payload = d;
    int v0 = validCnt;
    if (parityEn) payload[nBits-1] = parityOf(d, parityOdd) ^ flipPar;
    sendBit(1'b0, glitchAt == 0);
    for (int i = 0; i < nBits; i++) sendBit(payload[i], glitchAt == i + 1);
    sendBit(!badStop, glitchAt == nBits + 1);
    if (badStop) sendLevel(1'b1, 16);
    sendLevel(1'b1, 2);
    if (expectValid) begin
      check(validCnt == v0 + 1, {tag, " R2 valid count"}, validCnt, v0 + 1);
      check(capWord == d, {tag, " R2 word"}, capWord, d);
      check(capFe == badStop, {tag, " R4 framing"}, capFe, badStop);
      check(capPe == (parityEn && flipPar), {tag, " R3 parity"}, capPe, parityEn && flipPar);
      check(capNe == (glitchAt >= 0), {tag, " R5 noise"}, capNe, glitchAt >= 0);
    end else begin
      check(validCnt == v0, {tag, " ignored"}, validCnt, v0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int e0, b0, i0, o0;
    void'($urandom(32'h1a2b3c4d));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(dataValid == 0 && standby == 0 && rxWord == 0, "reset state", {rxWord, dataValid, standby}, 0);
    sendLevel(1'b1, 20);

    // R1 false start, R8 edge
    e0 = edgeCnt;
    i0 = validCnt;
    sendLevel(1'b0, 4);
    sendLevel(1'b1, 40);
    check(validCnt == i0, "R1 false start dropped", validCnt, i0);
    check(edgeCnt == e0 + 1, "R8 edge on false start", edgeCnt, e0 + 1);

    // directed frames across formats
    runFrame(10'h0A5, 0, 0, -1, 1, "8bit");
    pulseAck();
    wordMode = 2'd1; runFrame(10'h1C3, 0, 0, -1, 1, "9bit");
    pulseAck();
    wordMode = 2'd2; runFrame(10'h2F1, 0, 0, -1, 1, "10bit");
    pulseAck();
    parityEn = 1; parityOdd = 1; wordMode = 2'd0;
    runFrame(10'h055, 1, 0, -1, 1, "R3 odd parity error");
    pulseAck();
    parityEn = 0; parityOdd = 0;
    runFrame(10'h0F0, 0, 0, 3, 1, "R5 glitch in data bit");
    pulseAck();

    // constrained random frames
    for (int k = 0; k < 30; k++) begin
      wordMode = 2'($urandom_range(0, 2));
      parityEn = 1'($urandom_range(0, 1));
      parityOdd = 1'($urandom_range(0, 1));
      runFrame(10'($urandom), $urandom_range(0, 4) == 0, $urandom_range(0, 5) == 0,
               ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 9)) : -1, 1, "random");
      pulseAck();
    end
    wordMode = 2'd0; parityEn = 0; parityOdd = 0;

    // R7 idle after a character
    runFrame(10'h033, 0, 0, -1, 1, "pre-idle");
    pulseAck();
    i0 = idleCnt;
    sendLevel(1'b1, 10 * 16 + 8);
    check(idleCnt == i0 + 1, "R7 idle pulse", idleCnt, i0 + 1);
    sendLevel(1'b1, 200);
    check(idleCnt == i0 + 1, "R7 single idle pulse", idleCnt, i0 + 1);

    // R9 inverted polarity
    @(negedge clk); invertRx = 1'b1; rxPin = 1'b0;
    sendLevel(1'b1, 20);
    runFrame(10'h09C, 0, 0, -1, 1, "R9 inverted");
    pulseAck();
    @(negedge clk); invertRx = 1'b0; rxPin = 1'b1;
    sendLevel(1'b1, 20);

    // R6 break enabled and disabled
    brk11En = 1; b0 = brkCnt;
    runFrame(10'h000, 0, 1, -1, 1, "break frame");
    check(brkCnt == b0, "R6 no break before 11 bits", brkCnt, b0);
    pulseAck();
    sendLevel(1'b0, 192); sendLevel(1'b1, 30);
    check(brkCnt == b0 + 1, "R6 break detected", brkCnt, b0 + 1);
    check(capFe == 1, "R4 break framing", capFe, 1);
    pulseAck();
    brk11En = 0; b0 = brkCnt;
    sendLevel(1'b0, 192); sendLevel(1'b1, 30);
    check(brkCnt == b0, "R6 break disabled", brkCnt, b0);
    pulseAck();

    // R10 overrun
    runFrame(10'h05A, 0, 0, -1, 1, "first");
    o0 = ovrCnt; i0 = validCnt;
    runFrame(10'h0C3, 0, 0, -1, 0, "R10 overrun");
    check(ovrCnt == o0 + 1, "R10 overrun flag", ovrCnt, o0 + 1);
    check(rxWord == 10'h05A, "R10 word kept", rxWord, 10'h05A);
    pulseAck();
    runFrame(10'h011, 0, 0, -1, 1, "R10 after ack");
    pulseAck();

    // R11 idle-line wakeup
    wakeMode = 2'd1;
    pulseStandby();
    check(standby == 1, "R11 standby entered", standby, 1);
    runFrame(10'h077, 0, 0, -1, 0, "R11 standby");
    i0 = idleCnt;
    sendLevel(1'b1, 10 * 16 + 8);
    check(idleCnt == i0 + 1 && standby == 0, "R11 woke on idle", standby, 0);
    runFrame(10'h0E7, 0, 0, -1, 1, "R11 after wake");
    pulseAck();

    // R12 address-mark wakeup, 9 data bits
    wakeMode = 2'd2; wordMode = 2'd1; matchEn = 1; matchAddr = 9'h005;
    pulseStandby();
    runFrame(10'h033, 0, 0, -1, 0, "R12 data in standby");
    runFrame(10'h106, 0, 0, -1, 0, "R12 other address");
    check(standby == 1, "R12 still standby", standby, 1);
    runFrame(10'h105, 0, 0, -1, 1, "R12 matching address");
    check(standby == 0, "R12 awake", standby, 0);
    pulseAck();
    runFrame(10'h044, 0, 0, -1, 1, "R12 data awake");
    pulseAck();
    runFrame(10'h107, 0, 0, -1, 0, "R12 foreign address");
    check(standby == 1, "R12 back to standby", standby, 1);
    matchEn = 0;
    runFrame(10'h1AA, 0, 0, -1, 1, "R12 any address");
    check(standby == 0, "R12 awake no match", standby, 0);
    pulseAck();
    wakeMode = 2'd0;
    @(negedge clk);
    check(standby == 0, "R12 mode off", standby, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule